// File: doc/BRIEF.md
# I2C Master Command Engine

This block is a bus master for a two-wire serial bus. A host runs a transfer one bus phase at a time. It pulses one command strobe: start, stop, repeated start, byte write, byte read or acknowledge. The engine then plays out that phase on the clock and data lines and raises `done` for one cycle when the phase is complete. The host sequences the phases itself. For example: start, address write, data write, then stop. A write that is followed by a repeated start, a read and a NACK gives a random read.

Both lines are open-drain. The engine only asserts a pull-down enable (`scl_pull`, `sda_pull`). When it releases a line, an external resistor pulls that line high. The returned data line is sampled through `sda_in`. A 7-bit reload value sets the bit rate. Each bit occupies four quarter-periods of `div_reload + 1` clocks, so the bit rate is fclk / (4 × (reload + 1)). For example, a 4 MHz clock with reload 9 gives 100 kHz. The engine leaves the clock line released (high) at the end of every command except STOP, which also releases the data line.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset `busy` and `done` are 0 and both pull-down enables are 0 (both lines released).
- R2: During byte transfers the clock line rises every 4 × (div_reload + 1) clocks. Each low phase and each high phase lasts 2 × (div_reload + 1) clocks.
- R3: START pulls the data line low while the clock line is high. It leaves the clock line high and the data line low.
- R4: STOP ends with the data line rising while the clock line is high. Afterwards both lines are released.
- R5: Repeated START releases the data line first, then the clock line, then pulls the data line low while the clock line is high. No stop condition appears on the bus.
- R6: A byte write sends `tx_byte` most-significant bit first. The data line changes only while the clock line is low, so each bit is stable at the rising clock edge.
- R7: A byte write adds a ninth clock with the data line released. The line level seen during that clock is stored in `slave_ack` (0 = ACK, 1 = NACK).
- R8: A byte read releases the data line, clocks in 8 bits most-significant first and presents them on `rx_byte`.
- R9: The acknowledge command gives one clock with the data line equal to `ack_val` (0 = ACK drives low, 1 = NACK releases).
- R10: A strobe that arrives while `busy` is 1 is ignored. It adds no clock pulse and starts no command afterwards.
- R11: A command accepted on clock edge E0 raises `done` for exactly one cycle after edge E0 + 1 + Q × (div_reload + 1). Q is 4 for start, stop, repeated start and acknowledge, 36 for a write and 32 for a read. `busy` is 1 from the edge after E0 until `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Strobe: generate START |
| cmd_stop | input | 1 | Strobe: generate STOP |
| cmd_rstart | input | 1 | Strobe: generate repeated START |
| cmd_write | input | 1 | Strobe: send `tx_byte` and sample the slave's ACK |
| cmd_read | input | 1 | Strobe: receive one byte |
| cmd_ack | input | 1 | Strobe: send the `ack_val` bit |
| tx_byte | input | 8 | Byte to send, latched when a command is accepted |
| ack_val | input | 1 | Acknowledge level (0 ACK, 1 NACK), latched when a command is accepted |
| div_reload | input | DIV_W | Quarter-period reload value |
| sda_in | input | 1 | Sampled data-line level |
| rx_byte | output | 8 | Last byte received |
| slave_ack | output | 1 | ACK bit seen on the ninth clock of the last write |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| scl_pull | output | 1 | Clock-line pull-down enable |
| sda_pull | output | 1 | Data-line pull-down enable |

## Verification
The bench keeps the default DIV_W of 7 and changes the reload value at run time. Reloads 0 and 2 keep the nine-clock write short, so every command type and both ACK polarities fit in a few thousand cycles. The largest reload, 127, exercises the full width of the quarter counter and confirms that the bit timing scales with the reload. A bench-side slave resolves the open-drain lines, drives ACK and read data on clock falls, and detects start and stop conditions from the line edges.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_rstart,
  input  logic             cmd_write,
  input  logic             cmd_read,
  input  logic             cmd_ack,
  input  logic [7:0]       tx_byte,
  input  logic             ack_val,
  input  logic [DIV_W-1:0] div_reload,
  input  logic             sda_in,
  output logic [7:0]       rx_byte,
  output logic             slave_ack,
  output logic             busy,
  output logic             done,
  output logic             scl_pull,
  output logic             sda_pull
);

  typedef enum logic [2:0] {OP_NONE, OP_START, OP_STOP, OP_RST, OP_WR, OP_RD, OP_ACK} op_t;

  op_t             op, op_sel;
  logic [DIV_W-1:0] qcnt;
  logic [1:0]      qph;
  logic [3:0]      bitn;
  logic            fin, ackv;
  logic [7:0]      shreg;
  logic [3:0]      nbits;
  logic            lastbit;

  always_comb begin
    op_sel = OP_NONE;
    if      (cmd_start)  op_sel = OP_START;
    else if (cmd_rstart) op_sel = OP_RST;
    else if (cmd_stop)   op_sel = OP_STOP;
    else if (cmd_write)  op_sel = OP_WR;
    else if (cmd_read)   op_sel = OP_RD;
    else if (cmd_ack)    op_sel = OP_ACK;
  end

  assign nbits   = (op == OP_WR) ? 4'd9 : (op == OP_RD) ? 4'd8 : 4'd1;
  assign lastbit = (bitn == nbits - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op <= OP_NONE; qcnt <= '0; qph <= '0; bitn <= '0; fin <= 1'b0;
      ackv <= 1'b0; shreg <= '0; rx_byte <= '0; slave_ack <= 1'b0;
      busy <= 1'b0; done <= 1'b0; scl_pull <= 1'b0; sda_pull <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (op_sel != OP_NONE) begin
          op <= op_sel; busy <= 1'b1; qcnt <= '0; qph <= '0; bitn <= '0;
          fin <= 1'b0; shreg <= tx_byte; ackv <= ack_val;
        end
      end else if (qcnt != '0) begin
        qcnt <= qcnt - 1'b1;
      end else begin
        qcnt <= div_reload;
        if (fin) begin
          busy <= 1'b0; done <= 1'b1; op <= OP_NONE;
        end else begin
          unique case (op)
            OP_START: begin
              if (qph == 2'd0) begin scl_pull <= 1'b0; sda_pull <= 1'b0; end
              if (qph == 2'd2) sda_pull <= 1'b1;
            end
            OP_STOP: begin
              if (qph == 2'd0) scl_pull <= 1'b1;
              if (qph == 2'd1) sda_pull <= 1'b1;
              if (qph == 2'd2) scl_pull <= 1'b0;
              if (qph == 2'd3) sda_pull <= 1'b0;
            end
            OP_RST: begin
              if (qph == 2'd0) scl_pull <= 1'b1;
              if (qph == 2'd1) sda_pull <= 1'b0;
              if (qph == 2'd2) scl_pull <= 1'b0;
              if (qph == 2'd3) sda_pull <= 1'b1;
            end
            OP_WR: begin
              if (qph == 2'd0) scl_pull <= 1'b1;
              if (qph == 2'd1) sda_pull <= lastbit ? 1'b0 : ~shreg[7];
              if (qph == 2'd2) scl_pull <= 1'b0;
              if (qph == 2'd3) begin
                if (lastbit) slave_ack <= sda_in;
                else         shreg <= {shreg[6:0], 1'b0};
              end
            end
            OP_RD: begin
              if (qph == 2'd0) scl_pull <= 1'b1;
              if (qph == 2'd1) sda_pull <= 1'b0;
              if (qph == 2'd2) scl_pull <= 1'b0;
              if (qph == 2'd3) begin
                shreg <= {shreg[6:0], sda_in};
                if (lastbit) rx_byte <= {shreg[6:0], sda_in};
              end
            end
            OP_ACK: begin
              if (qph == 2'd0) scl_pull <= 1'b1;
              if (qph == 2'd1) sda_pull <= ~ackv;
              if (qph == 2'd2) scl_pull <= 1'b0;
            end
            default: ;
          endcase
          qph <= qph + 2'd1;
          if (qph == 2'd3) begin
            bitn <= bitn + 4'd1;
            if (lastbit) fin <= 1'b1;
          end
        end
      end
    end
  end

  // R10
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(op));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(qcnt) != '0 |-> $stable(scl_pull) && $stable(sda_pull));

  // R6
  wr_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op == OP_WR && !scl_pull && $past(!scl_pull) && $past(busy) |-> $stable(sda_pull));

  // R4
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(op) == OP_STOP |-> !scl_pull && !sda_pull);

endmodule

// File: tb/i2c_cmd_master_tb_top.sv
module i2c_cmd_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] strobe = '0;
  logic [7:0] tx_byte = '0;
  logic ack_val = 1'b0;
  logic [6:0] reload = 7'd2;
  logic [7:0] rx_byte;
  logic slave_ack, busy, done, scl_pull, sda_pull;
  logic slv_pull = 1'b0;
  wire  scl_bus = ~scl_pull;
  wire  sda_bus = ~(sda_pull | slv_pull);

  int n_chk = 0, n_bad = 0, cyc = 0;
  int rise_cnt = 0, last_rise = -1, last_fall = -1, gap_bad = 0, exp_q = 3;
  int start_cnt = 0, stop_cnt = 0, sda_rise_t = -1, scl_rise_t = -1;
  logic [8:0] cap = '0;
  int slv_mode = 0;
  logic [7:0] slv_data = '0;
  logic slv_nack = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  i2c_cmd_master #(.DIV_W(7)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(strobe[0]), .cmd_stop(strobe[1]), .cmd_rstart(strobe[2]),
    .cmd_write(strobe[3]), .cmd_read(strobe[4]), .cmd_ack(strobe[5]),
    .tx_byte(tx_byte), .ack_val(ack_val), .div_reload(reload), .sda_in(sda_bus),
    .rx_byte(rx_byte), .slave_ack(slave_ack), .busy(busy), .done(done),
    .scl_pull(scl_pull), .sda_pull(sda_pull));

  always @(posedge scl_bus) begin
    cap = {cap[7:0], sda_bus};
    if (rise_cnt > 0 && (cyc - last_rise) != 4 * exp_q) gap_bad++;
    if (last_fall >= 0 && (cyc - last_fall) != 2 * exp_q) gap_bad++;
    rise_cnt++; last_rise = cyc; scl_rise_t = cyc;
  end
  always @(negedge scl_bus) begin
    if (rise_cnt > 0 && (cyc - last_rise) != 2 * exp_q) gap_bad++;
    last_fall = cyc;
    if (slv_mode == 1) slv_pull <= (rise_cnt == 8) && !slv_nack;
    else if (slv_mode == 2) slv_pull <= (rise_cnt < 8) ? ~slv_data[7 - rise_cnt] : 1'b0;
    else slv_pull <= 1'b0;
  end
  always @(negedge sda_bus) if (scl_bus) start_cnt++;
  always @(posedge sda_bus) begin
    if (scl_bus) stop_cnt++;
    sda_rise_t = cyc;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic prep(input int mode);
    slv_mode = mode; rise_cnt = 0; last_rise = -1; last_fall = -1; gap_bad = 0;
    exp_q = int'(reload) + 1; sda_rise_t = -1; scl_rise_t = -1;
  endtask

  task automatic issue(input int c, input int nq, input bit poke, input string rq);
    int n = 0;
    int expn = 1 + nq * (int'(reload) + 1);
    @(negedge clk); strobe = '0; strobe[c] = 1'b1;
    @(negedge clk); strobe = '0;
    chk(busy == 1'b1, {rq, " R11 busy"}, busy, 1);
    while (!done && n < 20000) begin
      @(negedge clk); n++;
      strobe = (poke && n == 10) ? 6'b010000 : 6'b000000;
    end
    chk(n == expn, {rq, " R11 latency"}, n, expn);
    @(negedge clk);
    chk(!done, {rq, " R11 one-cycle done"}, done, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    chk(!scl_pull && !sda_pull, "R1 lines", {scl_pull, sda_pull}, 0);
  endtask

  task automatic t_start;
    int s0 = start_cnt;
    prep(0);
    issue(0, 4, 1'b0, "R3");
    chk(start_cnt == s0 + 1, "R3 start event", start_cnt - s0, 1);
    chk(scl_bus && !sda_bus, "R3 end lines", {scl_bus, sda_bus}, 2);
  endtask

  task automatic t_write(input logic [7:0] b, input bit nack, input bit poke);
    int s0 = start_cnt, p0 = stop_cnt;
    prep(1); slv_nack = nack; tx_byte = b;
    issue(3, 36, poke, "R6");
    chk(cap[8:1] == b, "R6 byte MSB first", cap[8:1], b);
    chk(slave_ack == nack, "R7 slave ack", slave_ack, nack);
    chk(gap_bad == 0, "R2 bit timing", gap_bad, 0);
    chk(start_cnt == s0 && stop_cnt == p0, "R6 no SDA change with SCL high",
        start_cnt - s0 + stop_cnt - p0, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(!busy && rise_cnt == 9, "R10 ignored strobe", rise_cnt, 9);
    end
  endtask

  task automatic t_read(input logic [7:0] b);
    prep(2); slv_data = b;
    issue(4, 32, 1'b0, "R8");
    chk(rx_byte == b, "R8 rx byte", rx_byte, b);
    chk(rise_cnt == 8, "R8 clock count", rise_cnt, 8);
    chk(gap_bad == 0, "R2 read timing", gap_bad, 0);
  endtask

  task automatic t_ack(input bit v);
    prep(0); ack_val = v;
    issue(5, 4, 1'b0, "R9");
    chk(cap[0] == v, "R9 ack level", cap[0], v);
  endtask

  task automatic t_rstart;
    int s0 = start_cnt, p0 = stop_cnt;
    prep(0);
    issue(2, 4, 1'b0, "R5");
    chk(sda_rise_t >= 0 && sda_rise_t < scl_rise_t, "R5 SDA before SCL", sda_rise_t, scl_rise_t);
    chk(start_cnt == s0 + 1, "R5 start event", start_cnt - s0, 1);
    chk(stop_cnt == p0, "R5 no stop", stop_cnt - p0, 0);
  endtask

  task automatic t_stop;
    int p0 = stop_cnt;
    prep(0);
    issue(1, 4, 1'b0, "R4");
    chk(stop_cnt == p0 + 1, "R4 stop event", stop_cnt - p0, 1);
    chk(!scl_pull && !sda_pull, "R4 released", {scl_pull, sda_pull}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    reload = 7'd2;
    t_start();
    t_write(8'hA5, 1'b0, 1'b1);
    reload = 7'd0;
    t_write(8'h3C, 1'b1, 1'b0);
    reload = 7'd2;
    t_read(8'h96);
    t_ack(1'b0);
    t_rstart();
    t_write(8'h5A, 1'b0, 1'b0);
    t_read(8'h0F);
    t_ack(1'b1);
    t_stop();
    t_start();
    reload = 7'd127;
    t_write(8'hC3, 1'b0, 1'b0);
    t_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule